// File: doc/BRIEF.md
# Dual Prescaled Down-Counting Timer

This peripheral holds two identical timers that count down, each behind a small window of 32-bit registers. Software writes a start value, then a control word that turns the timer on, picks a clock divider and chooses between repeating and single-shot operation. While the timer runs, its live count can be read back at any time.

When a timer's count steps from 1 to 0, that timer raises a level interrupt. The interrupt stays high until software writes to that timer's clear register. A repeating timer reloads its start value on that same step and keeps running. A single-shot timer stops at zero.

Register accesses take one cycle. A write commits on the clock edge at which `bus_sel` and `bus_wr` are high. A read returns data combinationally on `bus_rdata` while `bus_sel` is high and `bus_wr` is low.

Top module: `dual_dtimer`

## Requirements
- R1: After reset, every register of both timers reads 0 and both `irq` bits are low.
- R2: Timer k occupies byte offsets 0x20*k to 0x20*k+0x1F. Inside a window, offset 0x0 is the load register and reads back the last value written. Offset 0x4 returns the live count, offset 0x8 is control and offset 0xC is interrupt clear, which reads 0. Offsets 0x10 to 0x1C read 0 and ignore writes. Address bits [1:0] are ignored.
- R3: In the control word, bit 7 is enable, bit 6 selects repeating mode (0 means single-shot) and bits [3:2] hold the divider code. Control reads back only these bits, with all other bits 0.
- R4: Divider codes 0, 1 and 2 decrement the count once every 1, 16 and 256 clocks. Code 3 behaves as 256. The first decrement lands N clocks after the control write that enables the timer, where N is the divide ratio.
- R5: A write to the load register sets both the load value and the count to the written data, bits [23:0]. It also restarts the divider phase, even while the timer is running.
- R6: In single-shot mode, stepping from 1 to 0 sets the interrupt, and the count then stays at 0 with the timer stopped.
- R7: In repeating mode, stepping from 1 to 0 sets the interrupt and puts the load value into the count on that same edge, so counting carries on.
- R8: `irq[k]` stays high until a write to timer k's clear offset, whatever the data. A clear has no effect on the other timer. If an expiry and a clear land on the same edge, the expiry wins.
- R9: Writing a control word with bit 7 clear freezes the count.
- R10: An enabled timer whose count is already 0 stays at 0 and never raises its interrupt.
- R11: The count register returns the live value on every read, whether the timer is running or stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, releases after two clocks |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| irq | output | 2 | Level interrupt per timer, bit k for timer k |

## Verification
A divider phase that is off by even one clock moves each decrement. The error shows in the first count read after N clocks, and the bench samples exactly at the 16- and 256-clock boundaries. A pending flag that is set or cleared wrongly shows on `irq` on the very next edge. Checks cover clears to the wrong window and the case where a clear and an expiry land on the same edge. A wrong reload or stop decision after expiry shows in the count read one clock later: it is 0 when it should equal the load value, or the reverse.

// File: rtl/dtm_pkg.sv
package dtm_pkg;

  localparam int PSC_W = 8;

  typedef struct packed {
    logic       en;
    logic       per;
    logic [1:0] psc;
  } tmr_ctrl_t;

  typedef enum logic [1:0] {
    REG_LOAD = 2'd0,
    REG_CNT  = 2'd1,
    REG_CTRL = 2'd2,
    REG_CLR  = 2'd3
  } reg_sel_t;

  // last phase value before a tick, per divider code
  function automatic logic [PSC_W-1:0] psc_limit(input logic [1:0] code);
    case (code)
      2'd0:    psc_limit = PSC_W'(0);
      2'd1:    psc_limit = PSC_W'(15);
      default: psc_limit = PSC_W'(255);
    endcase
  endfunction

endpackage

// File: rtl/dtm_reset_sync.sv
module dtm_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_core_n = sync_q[1];
endmodule

// File: rtl/dtm_prescaler.sv
module dtm_prescaler
  import dtm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] code,
  output logic       tick
);
  logic [PSC_W-1:0] phase_q, phase_d;
  logic [PSC_W-1:0] limit;

  always_comb begin
    limit = psc_limit(code);
    tick  = run && (phase_q == limit);
    if (restart || !run || tick) phase_d = '0;
    else                         phase_d = phase_q + PSC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end
endmodule

// File: rtl/dtm_channel.sv
module dtm_channel
  import dtm_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_load,
  input  logic             wr_ctrl,
  input  logic             wr_clr,
  input  logic [CNT_W-1:0] ld_data,
  input  tmr_ctrl_t        ctrl_data,
  output logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt_val,
  output tmr_ctrl_t        ctrl_val,
  output logic             irq
);
  logic [CNT_W-1:0] load_q, load_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  tmr_ctrl_t        ctrl_q, ctrl_d;
  logic             run_q, run_d;
  logic             pend_q, pend_d;
  logic             expire;
  logic             tick;

  dtm_prescaler u_psc (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run_q),
    .restart (wr_load | wr_ctrl),
    .code    (ctrl_q.psc),
    .tick    (tick)
  );

  always_comb begin
    load_d = load_q;
    cnt_d  = cnt_q;
    ctrl_d = ctrl_q;
    run_d  = run_q;
    expire = 1'b0;

    if (wr_load) begin
      load_d = ld_data;
      cnt_d  = ld_data;
    end else if (run_q && tick) begin
      if (cnt_q == CNT_W'(1)) begin
        expire = 1'b1;
        if (ctrl_q.per) begin
          cnt_d = load_q;
        end else begin
          cnt_d = '0;
          run_d = 1'b0;
        end
      end else if (cnt_q == '0) begin
        run_d = 1'b0;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end

    if (wr_ctrl) begin
      ctrl_d = ctrl_data;
      run_d  = ctrl_data.en;
    end

    if (expire)      pend_d = 1'b1;
    else if (wr_clr) pend_d = 1'b0;
    else             pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= '0;
      cnt_q  <= '0;
      ctrl_q <= '0;
      run_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      load_q <= load_d;
      cnt_q  <= cnt_d;
      ctrl_q <= ctrl_d;
      run_q  <= run_d;
      pend_q <= pend_d;
    end
  end

  assign load_val = load_q;
  assign cnt_val  = cnt_q;
  assign ctrl_val = ctrl_q;
  assign irq      = pend_q;
endmodule

// File: rtl/dual_dtimer.sv
module dual_dtimer
  import dtm_pkg::*;
#(
  parameter  int N_TMR  = 2,
  parameter  int CNT_W  = 24,
  localparam int IDX_W  = (N_TMR > 1) ? $clog2(N_TMR) : 1,
  localparam int ADDR_W = 5 + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [N_TMR-1:0]  irq
);
  logic                        rst_core_n;
  logic [IDX_W-1:0]            win;
  logic [2:0]                  off;
  reg_sel_t                    rsel;
  logic                        hit;
  logic                        acc_wr;
  tmr_ctrl_t                   ctrl_in;
  logic [N_TMR-1:0]            wr_load, wr_ctrl, wr_clr;
  logic [N_TMR-1:0][CNT_W-1:0] load_vec;
  logic [N_TMR-1:0][CNT_W-1:0] cnt_vec;
  tmr_ctrl_t [N_TMR-1:0]       ctrl_vec;
  logic                        unused_bits;

  dtm_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  always_comb begin
    win     = bus_addr[ADDR_W-1:5];
    off     = bus_addr[4:2];
    rsel    = reg_sel_t'(off[1:0]);
    hit     = !off[2] && ({1'b0, win} < (IDX_W+1)'(N_TMR));
    acc_wr  = bus_sel && bus_wr && hit;
    ctrl_in = '{en: bus_wdata[7], per: bus_wdata[6], psc: bus_wdata[3:2]};
  end

  assign unused_bits = ^{bus_wdata[31:CNT_W], bus_wdata[5:4], bus_wdata[1:0], bus_addr[1:0]};

  for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
    always_comb begin
      wr_load[i] = acc_wr && (win == IDX_W'(i)) && (rsel == REG_LOAD);
      wr_ctrl[i] = acc_wr && (win == IDX_W'(i)) && (rsel == REG_CTRL);
      wr_clr[i]  = acc_wr && (win == IDX_W'(i)) && (rsel == REG_CLR);
    end

    dtm_channel #(.CNT_W(CNT_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_core_n),
      .wr_load   (wr_load[i]),
      .wr_ctrl   (wr_ctrl[i]),
      .wr_clr    (wr_clr[i]),
      .ld_data   (bus_wdata[CNT_W-1:0]),
      .ctrl_data (ctrl_in),
      .load_val  (load_vec[i]),
      .cnt_val   (cnt_vec[i]),
      .ctrl_val  (ctrl_vec[i]),
      .irq       (irq[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr && hit) begin
      case (rsel)
        REG_LOAD: bus_rdata = 32'(load_vec[win]);
        REG_CNT:  bus_rdata = 32'(cnt_vec[win]);
        REG_CTRL: bus_rdata = {24'b0, ctrl_vec[win].en, ctrl_vec[win].per,
                               2'b00, ctrl_vec[win].psc, 2'b00};
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/dtm_sva.sv
module dtm_sva #(
  parameter int N_TMR  = 2,
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 6
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        bus_sel,
  input logic                        bus_wr,
  input logic [ADDR_W-1:0]           bus_addr,
  input logic [31:0]                 bus_rdata,
  input logic [N_TMR-1:0]            irq,
  input logic [N_TMR-1:0][CNT_W-1:0] cnt_vec
);

  always @(negedge clk) begin
    if (!rst_n) AST_RST_QUIET: assert (irq == '0); // R1
  end

  AST_CTRL_RB: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr[4:2] == 3'b010) |-> ((bus_rdata & 32'hFFFF_FF33) == 32'h0)); // R3

  for (genvar i = 0; i < N_TMR; i++) begin : g_chk
    logic to_me, clr_me, ld_me;
    assign to_me  = bus_sel && bus_wr && (bus_addr[ADDR_W-1:5] == (ADDR_W-5)'(i));
    assign clr_me = to_me && (bus_addr[4:2] == 3'b011);
    assign ld_me  = to_me && (bus_addr[4:2] == 3'b000);

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (irq[i] && !clr_me) |=> irq[i]); // R8

    AST_IRQ_FROM_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq[i]) |-> ($past(cnt_vec[i]) == CNT_W'(1))); // R6

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_vec[i] > CNT_W'(1) && !ld_me) |=>
        (cnt_vec[i] == $past(cnt_vec[i]) || cnt_vec[i] == $past(cnt_vec[i]) - CNT_W'(1))); // R4
  end
endmodule

bind dual_dtimer dtm_sva #(.N_TMR(N_TMR), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .cnt_vec   (cnt_vec)
);

// File: tb/sim_dual_dtimer.sv
module sim_dual_dtimer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [1:0]  irq;
  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  dual_dtimer u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  typedef struct packed {
    logic        tmr;
    logic [1:0]  psc;
    logic        per;
    logic [23:0] load;
    logic [15:0] wait_n;
    logic [23:0] ecnt;
    logic [1:0]  eirq;
  } vec_t;

  localparam vec_t VECS [14] = '{
    '{1'b0, 2'd0, 1'b0, 24'd10, 16'd4,   24'd6, 2'b00},
    '{1'b0, 2'd0, 1'b0, 24'd10, 16'd10,  24'd0, 2'b01},
    '{1'b0, 2'd0, 1'b0, 24'd10, 16'd15,  24'd0, 2'b01},
    '{1'b0, 2'd0, 1'b1, 24'd5,  16'd5,   24'd5, 2'b01},
    '{1'b0, 2'd0, 1'b1, 24'd5,  16'd7,   24'd3, 2'b01},
    '{1'b1, 2'd1, 1'b0, 24'd3,  16'd32,  24'd1, 2'b00},
    '{1'b1, 2'd1, 1'b0, 24'd3,  16'd47,  24'd1, 2'b00},
    '{1'b1, 2'd1, 1'b0, 24'd3,  16'd48,  24'd0, 2'b10},
    '{1'b0, 2'd2, 1'b0, 24'd2,  16'd256, 24'd1, 2'b00},
    '{1'b0, 2'd2, 1'b0, 24'd2,  16'd511, 24'd1, 2'b00},
    '{1'b0, 2'd2, 1'b0, 24'd2,  16'd512, 24'd0, 2'b01},
    '{1'b1, 2'd3, 1'b0, 24'd1,  16'd255, 24'd1, 2'b00},
    '{1'b1, 2'd3, 1'b0, 24'd1,  16'd256, 24'd0, 2'b10},
    '{1'b1, 2'd0, 1'b1, 24'hFFFFFF, 16'd3, 24'hFFFFFC, 2'b00}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic quiet_all();
    wr(6'h08, 32'h0); wr(6'h28, 32'h0);
    wr(6'h0C, 32'h0); wr(6'h2C, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [5:0]  base;
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    wait_cyc(3);

    // R1 reset state
    rd(6'h00, r); check("R1 load0", r, 0);
    rd(6'h04, r); check("R1 cnt0", r, 0);
    rd(6'h08, r); check("R1 ctrl0", r, 0);
    rd(6'h24, r); check("R1 cnt1", r, 0);
    check("R1 irq", 32'(irq), 0);

    // vector table: R4 R6 R7 R11
    foreach (VECS[i]) begin
      base = VECS[i].tmr ? 6'h20 : 6'h00;
      quiet_all();
      wr(base, 32'(VECS[i].load));
      wr(base + 6'h08, 32'h80 | (32'(VECS[i].per) << 6) | (32'(VECS[i].psc) << 2));
      wait_cyc(VECS[i].wait_n);
      rd(base + 6'h04, r);
      check($sformatf("R4/R6/R7/R11 vec%0d cnt", i), r, 32'(VECS[i].ecnt));
      check($sformatf("R6/R7 vec%0d irq", i), 32'(irq), 32'(VECS[i].eirq));
    end

    // R3 control readback, R2 byte bits ignored
    quiet_all();
    wr(6'h28, 32'hFFFF_FFFF);
    rd(6'h28, r); check("R3 ctrl readback", r, 32'hCC);
    rd(6'h2B, r); check("R2 low addr bits", r, 32'hCC);
    wr(6'h28, 32'h0);

    // R5 preload while running, then phase restart under /16
    quiet_all();
    wr(6'h00, 32'd100); wr(6'h08, 32'h80);
    wait_cyc(10);
    rd(6'h04, r); check("R11 live cnt", r, 90);
    wr(6'h00, 32'd50);
    rd(6'h04, r); check("R5 preload", r, 50);
    wait_cyc(3);
    rd(6'h04, r); check("R5 continues", r, 47);
    wr(6'h00, 32'd5); wr(6'h08, 32'h84);
    wait_cyc(10);
    wr(6'h00, 32'd5);
    wait_cyc(15);
    rd(6'h04, r); check("R5 phase restart hold", r, 5);
    wait_cyc(1);
    rd(6'h04, r); check("R5 phase restart step", r, 4);

    // R9 disable freezes
    quiet_all();
    wr(6'h00, 32'd100); wr(6'h08, 32'h80);
    wait_cyc(5);
    rd(6'h04, r); check("R9 before stop", r, 95);
    wr(6'h08, 32'h0);
    wait_cyc(10);
    rd(6'h04, r); check("R9 frozen", r, 94);

    // R10 enabled with zero count
    quiet_all();
    wr(6'h00, 32'd0); wr(6'h08, 32'hC0);
    wait_cyc(20);
    rd(6'h04, r); check("R10 cnt stays 0", r, 0);
    check("R10 no irq", 32'(irq), 0);

    // R8 expiry and clear on the same edge: expiry wins
    quiet_all();
    wr(6'h00, 32'd3); wr(6'h08, 32'h80);
    wait_cyc(2);
    wr(6'h0C, 32'h0);
    check("R8 set beats clear", 32'(irq), 32'b01);

    // R2 ignored window offsets, R8 per-timer clear with any data
    quiet_all();
    wr(6'h00, 32'd1); wr(6'h20, 32'd1);
    wr(6'h08, 32'h80); wr(6'h28, 32'h80);
    wait_cyc(3);
    check("R8 both pending", 32'(irq), 32'b11);
    wr(6'h1C, 32'hFFFF_FFFF);
    wr(6'h10, 32'd77);
    check("R2 reserved write no clear", 32'(irq), 32'b11);
    rd(6'h00, r); check("R2 reserved write no load", r, 1);
    rd(6'h14, r); check("R2 reserved read", r, 0);
    rd(6'h0C, r); check("R2 clear reads 0", r, 0);
    wr(6'h0C, 32'hDEAD_BEEF);
    check("R8 clear timer0 only", 32'(irq), 32'b10);
    wait_cyc(5);
    check("R8 timer1 held", 32'(irq), 32'b10);
    wr(6'h2C, 32'h0);
    check("R8 clear timer1", 32'(irq), 32'b00);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule